// File: doc/BRIEF.md
# Push-Button Single-Shot Serial Transmitter

This block sends one asynchronous serial frame each time an active-low start button is pressed. It sends only one frame however long the button stays down. Both button inputs pass through a two-flop synchroniser and a counter-based debouncer, so every register in the block runs on the system clock and none is clocked by a button. A second active-low button advances the byte code to send. The byte code is the 8-bit base value on `base_i` plus the number of accepted "next" presses since reset, taken modulo 256.

The framing state machine sends 8N1 frames. After the stop bit it moves to a cleanup state, where it drops the active flag and raises the done flag. It stays there while the transmit request is still high and goes back to idle only when the request falls. The request can come from one of two sources, chosen by a parameter. In level mode the debounced button is the request. In pulse mode each press produces a request pulse of a fixed length that is shorter than one frame.

Top module: `btn_uart_tx`

## Requirements
- R1: During reset and after it, `tx_o` is 1 and `active_o` and `done_o` are 0 until a press is accepted.
- R2: A frame is one low start bit, then the eight data bits least significant bit first, then one high stop bit. The line is high between frames.
- R3: Each bit of a frame holds for exactly `CLKS_PER_BIT` clock cycles.
- R4: In level mode a held start button produces exactly one frame. While the button stays down after that frame, `tx_o` stays 1, `active_o` stays 0 and `done_o` stays 1.
- R5: `done_o` falls once the request drops. In level mode this happens when the button is released. A new press after that sends a new frame.
- R6: The byte sent equals `base_i` plus the count of accepted "next" presses, modulo 256. Each debounced press of `next_ni` adds one.
- R7: The byte is captured when the frame leaves idle. Changing `base_i` during a frame does not change that frame.
- R8: A button level is accepted only after it has been stable for `DEB_CYCLES` synchronised cycles. A shorter glitch on `start_ni` sends no frame.
- R9: In pulse mode (`PULSE_MODE`=1) a press creates a request lasting `PULSE_CLKS` cycles, which must be fewer than one frame. Exactly one frame is sent, and `done_o` falls after the frame even while the button stays down.
- R10: `active_o` is 1 from the first cycle of the start bit through the last cycle of the stop bit, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_ni | input | 1 | Start button, active low |
| next_ni | input | 1 | Next-byte button, active low |
| base_i | input | 8 | Base byte code |
| tx_o | output | 1 | Serial output line, idle high |
| active_o | output | 1 | High while a frame is on the line |
| done_o | output | 1 | High in cleanup, after the stop bit |

## Verification
A state machine that fails to park in cleanup shows up as a second start bit on `tx_o` within one debounce window plus one cycle after the stop bit, while the button is still held. A wrong bit counter lengthens or shortens the start bit, and this can be measured at the line in the first frame. A byte register that is not captured on entry from idle shows up as corrupted data bits within one bit period after `base_i` changes mid-frame. A wrong step count shows up in the data bits of the next frame.

// File: rtl/btn_uart_pkg.sv
package btn_uart_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_CLEANUP
  } tx_state_e;
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic level_o
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          pressed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], btn_ni};
  end

  assign pressed = ~sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (pressed == level_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
      cnt_q   <= '0;
      level_q <= pressed;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;

  // R8
  deb_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(cnt_q) == CW'(DEB_CYCLES - 1)));
endmodule

// File: rtl/byte_stepper.sv
module byte_stepper #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          next_lvl_i,
  input  logic [DW-1:0] base_i,
  output logic [DW-1:0] sel_o
);
  logic          prev_q;
  logic [DW-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      step_q <= '0;
    end else begin
      prev_q <= next_lvl_i;
      if (next_lvl_i && !prev_q) step_q <= step_q + 1'b1;
    end
  end

  assign sel_o = base_i + step_q;

  // R6
  step_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != $past(step_q)) |-> ($past(next_lvl_i) && !$past(prev_q)));
endmodule

// File: rtl/req_gen.sv
module req_gen #(
  parameter bit PULSE_MODE = 1'b0,
  parameter int PULSE_CLKS = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_lvl_i,
  output logic req_o
);
  if (PULSE_MODE) begin : g_pulse
    localparam int PW = $clog2(PULSE_CLKS + 1);
    logic          prev_q;
    logic [PW-1:0] left_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        left_q <= '0;
      end else begin
        prev_q <= start_lvl_i;
        if (start_lvl_i && !prev_q)  left_q <= PW'(PULSE_CLKS);
        else if (left_q != '0)       left_q <= left_q - 1'b1;
      end
    end

    assign req_o = (left_q != '0);

    // R9
    pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_o) |-> ($past(start_lvl_i) && !$past(prev_q)));
  end else begin : g_level
    assign req_o = start_lvl_i;
  end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
  import btn_uart_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1250,
  parameter int DW           = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [DW-1:0] byte_i,
  output logic          tx_o,
  output logic          active_o,
  output logic          done_o
);
  localparam int BW = $clog2(CLKS_PER_BIT + 1);
  localparam int IW = $clog2(DW);

  tx_state_e     state_q;
  logic [BW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] data_q;
  logic          bit_end;

  assign bit_end = (cnt_q == BW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      cnt_q <= (state_q == ST_IDLE || state_q == ST_CLEANUP || bit_end) ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          data_q  <= byte_i;
          idx_q   <= '0;
          state_q <= ST_START;
        end
        ST_START: if (bit_end) state_q <= ST_DATA;
        ST_DATA: if (bit_end) begin
          if (idx_q == IW'(DW - 1)) state_q <= ST_STOP;
          else                      idx_q   <= idx_q + 1'b1;
        end
        ST_STOP:    if (bit_end) state_q <= ST_CLEANUP;
        ST_CLEANUP: if (!req_i)  state_q <= ST_IDLE;  // park while request held
        default:                 state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_o     = (state_q == ST_START) ? 1'b0 :
                    (state_q == ST_DATA)  ? data_q[idx_q] : 1'b1;
  assign active_o = (state_q == ST_START) || (state_q == ST_DATA) || (state_q == ST_STOP);
  assign done_o   = (state_q == ST_CLEANUP);

  // R4
  park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLEANUP && req_i) |=> (state_q == ST_CLEANUP));
  // R3
  bit_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < BW'(CLKS_PER_BIT));
  // R7
  latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(data_q));
  // R10
  active_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> ($past(state_q) == ST_IDLE && $past(req_i)));
  // R5
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(active_o && done_o));
endmodule

// File: rtl/btn_uart_tx.sv
module btn_uart_tx #(
  parameter int CLKS_PER_BIT = 1250,
  parameter int DEB_CYCLES   = 100000,
  parameter bit PULSE_MODE   = 1'b0,
  parameter int PULSE_CLKS   = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_ni,
  input  logic       next_ni,
  input  logic [7:0] base_i,
  output logic       tx_o,
  output logic       active_o,
  output logic       done_o
);
  localparam int DW          = 8;
  localparam int FRAME_CLKS  = (DW + 2) * CLKS_PER_BIT;

  logic          start_lvl, next_lvl, req;
  logic [DW-1:0] sel_byte;

  btn_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb_start (
    .clk_i, .rst_ni, .btn_ni(start_ni), .level_o(start_lvl));

  btn_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb_next (
    .clk_i, .rst_ni, .btn_ni(next_ni), .level_o(next_lvl));

  byte_stepper #(.DW(DW)) u_step (
    .clk_i, .rst_ni, .next_lvl_i(next_lvl), .base_i, .sel_o(sel_byte));

  req_gen #(.PULSE_MODE(PULSE_MODE), .PULSE_CLKS(PULSE_CLKS)) u_req (
    .clk_i, .rst_ni, .start_lvl_i(start_lvl), .req_o(req));

  uart_tx_fsm #(.CLKS_PER_BIT(CLKS_PER_BIT), .DW(DW)) u_fsm (
    .clk_i, .rst_ni, .req_i(req), .byte_i(sel_byte),
    .tx_o, .active_o, .done_o);

  // R9
  initial pulse_fit_chk: assert (!PULSE_MODE || PULSE_CLKS < FRAME_CLKS);

  // R1
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> tx_o);
endmodule

// File: tb/btn_uart_tx_tb_top.sv
module btn_uart_tx_tb_top;
  localparam int CPB  = 8;
  localparam int DEB  = 4;
  localparam int PCLK = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       next_n = 1'b1;
  logic [7:0] base = 8'h00;
  logic       tx, active, done;
  logic       tx_p, active_p, done_p;

  int n_run = 0;
  int n_fail = 0;
  int steps = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  btn_uart_tx #(.CLKS_PER_BIT(CPB), .DEB_CYCLES(DEB), .PULSE_MODE(1'b0), .PULSE_CLKS(PCLK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_ni(start_n), .next_ni(next_n), .base_i(base),
    .tx_o(tx), .active_o(active), .done_o(done));

  btn_uart_tx #(.CLKS_PER_BIT(CPB), .DEB_CYCLES(DEB), .PULSE_MODE(1'b1), .PULSE_CLKS(PCLK)) dut_p_i (
    .clk_i(clk), .rst_ni(rst_n), .start_ni(start_n), .next_ni(next_n), .base_i(base),
    .tx_o(tx_p), .active_o(active_p), .done_o(done_p));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic line(input bit pm);
    return pm ? tx_p : tx;
  endfunction

  // wait for a start bit and sample at bit centres
  task automatic recv(input bit pm, output logic [7:0] b, output bit ok);
    int t = 0;
    ok = 1'b0;
    b = '0;
    while (line(pm) !== 1'b0 && t < 400) begin @(negedge clk); t++; end
    if (t >= 400) return;
    cyc(CPB / 2);
    if (line(pm) !== 1'b0) return;
    for (int i = 0; i < 8; i++) begin cyc(CPB); b[i] = line(pm); end
    cyc(CPB);
    ok = (line(pm) === 1'b1);
    cyc(CPB / 2);
  endtask

  task automatic press_next();
    next_n = 1'b0; cyc(DEB + 6);
    next_n = 1'b1; cyc(DEB + 6);
    steps++;
  endtask

  task automatic t_reset();
    check("R1 tx", tx, 1);
    check("R1 active", active, 0);
    check("R1 done", done, 0);
    rst_n = 1'b1;
    cyc(20);
    check("R1 tx after", tx, 1);
    check("R1 done after", done, 0);
  endtask

  task automatic t_basic_frame(input logic [7:0] bv);
    logic [7:0] b; bit ok;
    base = bv;
    start_n = 1'b0;
    recv(0, b, ok);
    check("R2 stop/start", ok, 1);
    check("R2 byte", b, 8'(bv + steps));
    start_n = 1'b1;
    cyc(DEB + 6);
    check("R5 done after release", done, 0);
    cyc(PCLK + 4 * CPB * 10);
  endtask

  task automatic t_bit_len();
    int t = 0; int low = 0; int act_len = 0;
    base = 8'(8'h01 - steps);  // byte 0x01: start bit alone low
    start_n = 1'b0;
    while (tx !== 1'b0 && t < 400) begin @(negedge clk); t++; end
    while (tx === 1'b0 && low < 100) begin
      if (active === 1'b1) act_len++;
      @(negedge clk); low++;
    end
    check("R3 start bit length", low, CPB);
    check("R10 active during start", act_len, CPB);
    cyc(9 * CPB);
    check("R10 active low after stop", active, 0);
    check("R5 done in cleanup", done, 1);
    start_n = 1'b1;
    cyc(PCLK + 4 * CPB * 10);
  endtask

  task automatic t_hold();
    logic [7:0] b; bit ok; int extra = 0; int badflag = 0;
    base = 8'h5A;
    start_n = 1'b0;
    recv(0, b, ok);
    check("R4 first frame", b, 8'(8'h5A + steps));
    for (int i = 0; i < 40 * CPB; i++) begin
      @(negedge clk);
      if (tx !== 1'b1) extra++;
      if (active !== 1'b0 || done !== 1'b1) badflag++;
    end
    check("R4 no repeat frame", extra, 0);
    check("R4 flags held", badflag, 0);
    check("R9 pulse done drops while held", done_p, 0);
    start_n = 1'b1;
    cyc(DEB + 6);
    check("R5 done cleared", done, 0);
    cyc(10);
  endtask

  task automatic t_step();
    logic [7:0] b; bit ok;
    base = 8'hF0;
    press_next();
    press_next();
    start_n = 1'b0;
    recv(0, b, ok);
    check("R6 stepped byte", b, 8'(8'hF0 + steps));
    start_n = 1'b1;
    cyc(PCLK + 4 * CPB * 10);
  endtask

  task automatic t_midframe();
    logic [7:0] b; bit ok; int t = 0;
    base = 8'h3C;
    start_n = 1'b0;
    while (active !== 1'b1 && t < 400) begin @(negedge clk); t++; end
    base = 8'hC3;
    recv(0, b, ok);
    check("R7 latched byte", b, 8'(8'h3C + steps));
    start_n = 1'b1;
    cyc(PCLK + 4 * CPB * 10);
  endtask

  task automatic t_glitch();
    int lows = 0; int acts = 0;
    start_n = 1'b0; cyc(2);
    start_n = 1'b1;
    for (int i = 0; i < 30 * CPB; i++) begin
      @(negedge clk);
      if (tx !== 1'b1) lows++;
      if (active !== 1'b0) acts++;
    end
    check("R8 glitch no frame", lows, 0);
    check("R8 glitch no active", acts, 0);
  endtask

  task automatic t_pulse();
    logic [7:0] b; bit ok; int extra = 0;
    base = 8'hA7;
    start_n = 1'b0;
    recv(1, b, ok);
    check("R9 pulse frame ok", ok, 1);
    check("R9 pulse byte", b, 8'(8'hA7 + steps));
    for (int i = 0; i < 30 * CPB; i++) begin
      @(negedge clk);
      if (tx_p !== 1'b1) extra++;
    end
    check("R9 single pulse frame", extra, 0);
    check("R9 done low while held", done_p, 0);
    start_n = 1'b1;
    cyc(PCLK + 4 * CPB * 10);
  endtask

  initial begin
    cyc(3);
    t_reset();
    t_basic_frame(8'hD2);
    t_basic_frame(8'h81);
    t_bit_len();
    t_hold();
    t_step();
    t_midframe();
    t_glitch();
    t_pulse();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule